// File: doc/BRIEF.md
# Phased Crosspoint Array Controller

This block turns microcoded switch commands into pin activity for an external 16 by 16 array of single-bit crosspoint switches. The array is made of two write-only devices of 8 rows by 16 columns each, placed side by side. Each command carries a 2-bit operation (idle, connect, disconnect or wipe), a 4-bit row and a 4-bit column. The block drives the device address, the data level, a per-device select, a per-device strobe and a shared reset line.

A free-running 2-bit phase counter divides time into slots of four clocks. A command is captured only on the clock edge that opens phase 0 of a slot. The pins are then shaped across that slot so that the address and data settle before the strobe and stay put after it. A one-clock done pulse tells the microsequencer when the slot ends. The array cannot be read back, so the block keeps a 256-bit shadow of every crosspoint for observation. A sequencer watches `phase_o` and presents its next command while phase 3 is shown.

Top module: `xbar_phase_ctrl`

## Requirements
- R1: After reset `phase_o` is 0. It then advances by one every clock, wrapping from 3 to 0, whether or not commands arrive.
- R2: The command inputs are sampled only on the clock edge at which `phase_o` goes from 3 to 0. Operation code 00 (idle) is ignored, and so is a command held only during phases 0 to 2. An ignored command produces no select, strobe, reset or done, and the shadow stays unchanged.
- R3: Connect is operation code 01 and disconnect is 10. For either one, `dev_addr` is {row[2:0], col[3:0]} and `dev_data` is 1 for connect and 0 for disconnect. Both values stay constant over all four phases of the slot.
- R4: For connect and disconnect, strobe bit row[3] is 1 in phases 1 and 2 only. The other device's strobe bit stays 0.
- R5: For connect and disconnect, select bit row[3] is 1 for all four phases of the slot. The other select bit stays 0.
- R6: Wipe is operation code 11. It holds `dev_reset` at 1 for all four phases of its slot with no select or strobe, and all 256 shadow bits read 0 from the next phase 0 on.
- R7: Every accepted command raises `cmd_done` for exactly one clock, during phase 3 of its slot.
- R8: Connect sets, and disconnect clears, shadow bit row*16+col. The new value is visible from the phase 0 that follows the slot, and all other bits keep their values.
- R9: While reset is asserted and after it, until a command is accepted, every pin output, `cmd_done` and the whole shadow are 0.
- R10: A command presented in the phase 3 of a busy slot is taken into the very next slot, so commands can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 2 | Operation: 00 idle, 01 connect, 10 disconnect, 11 wipe |
| cmd_row | input | 4 | Row select; bit 3 picks the device |
| cmd_col | input | 4 | Column select |
| phase_o | output | 2 | Current slot phase |
| dev_addr | output | 7 | Address inside the selected device: {row[2:0], col} |
| dev_data | output | 1 | Level to write: 1 closes, 0 opens |
| dev_cs | output | 2 | Per-device select |
| dev_strobe | output | 2 | Per-device write strobe |
| dev_reset | output | 1 | Reset to both devices |
| cmd_done | output | 1 | One-clock end-of-slot pulse |
| shadow | output | 256 | Copy of all crosspoints, bit row*16+col |

## Verification
The assertions assume that the command inputs are meaningful only when `phase_o` is 3, and that the sequencer follows that phase instead of counting on its own. They also assume the row and column fields always fall inside the array, which holds at the default widths. The stimulus changes inputs only on falling edges and times each command from `phase_o`. The one deliberate break of the timing rule is a command held over phases 0 to 2 and dropped before the sampling edge, which checks that the block ignores it.

// File: rtl/xbar_pkg.sv
// Shared definitions for the crosspoint array controller.
// Assumes the operation field is two bits wide.
package xbar_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_CONN  = 2'b01,
        OP_DISC  = 2'b10,
        OP_WIPE  = 2'b11
    } xbar_op_e;

    localparam int PHASES = 4;
endpackage

// File: rtl/xbar_phase_gen.sv
// Free-running four-phase slot counter.
// Outputs the phase number plus the derived strobe-window and last-phase enables.
// Assumes a synchronous active-low reset that returns the counter to phase 0.
module xbar_phase_gen
    import xbar_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            en_strobe,
    output logic            en_last
);
    localparam int NPH = 1 << PH_W;

    logic [NPH-1:0] ph_en;

    // Advance the phase counter every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // One-hot decode of the phase number.
    for (genvar p = 0; p < NPH; p++) begin : g_dec
        assign ph_en[p] = (phase == PH_W'(p));
    end

    // Strobe window covers the two middle phases; last phase closes the slot.
    always_comb begin
        en_strobe = ph_en[1] | ph_en[2];
        en_last   = ph_en[NPH-1];
    end
endmodule

// File: rtl/xbar_cmd_seq.sv
// Captures one command per slot and shapes the device pins across its phases.
// Assumes en_last is high in exactly one clock of every slot; the command is
// sampled on the edge that ends that clock, so it is held for a whole slot.
module xbar_cmd_seq
    import xbar_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DEV_SEL_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_strobe,
    input  logic                          en_last,
    input  logic [1:0]                    op,
    input  logic [ROW_W-1:0]              row,
    input  logic [COL_W-1:0]              col,
    output logic [ROW_W-DEV_SEL_W+COL_W-1:0] dev_addr,
    output logic                          dev_data,
    output logic [(1<<DEV_SEL_W)-1:0]     dev_cs,
    output logic [(1<<DEV_SEL_W)-1:0]     dev_strobe,
    output logic                          dev_reset,
    output logic                          done,
    output logic                          upd_wipe,
    output logic                          upd_level,
    output logic [ROW_W+COL_W-1:0]        upd_idx
);
    localparam int DEV_N     = 1 << DEV_SEL_W;
    localparam int LOC_ROW_W = ROW_W - DEV_SEL_W;

    logic             busy;
    xbar_op_e         op_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             is_wr;
    logic [DEV_SEL_W-1:0] dsel;

    // Latch the command at the slot boundary; idle leaves the slot empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            op_q  <= OP_IDLE;
            row_q <= '0;
            col_q <= '0;
        end else if (en_last) begin
            busy  <= (xbar_op_e'(op) != OP_IDLE);
            op_q  <= xbar_op_e'(op);
            row_q <= row;
            col_q <= col;
        end
    end

    // Shared pin levels held constant for the whole slot.
    always_comb begin
        is_wr     = busy && (op_q == OP_CONN || op_q == OP_DISC);
        dsel      = row_q[ROW_W-1 -: DEV_SEL_W];
        dev_addr  = is_wr ? {row_q[LOC_ROW_W-1:0], col_q} : '0;
        dev_data  = is_wr && (op_q == OP_CONN);
        dev_reset = busy && (op_q == OP_WIPE);
        done      = busy && en_last;
    end

    // Per-device select and strobe.
    for (genvar d = 0; d < DEV_N; d++) begin : g_dev
        assign dev_cs[d]     = is_wr && (dsel == DEV_SEL_W'(d));
        assign dev_strobe[d] = dev_cs[d] && en_strobe;
    end

    // Shadow update request, valid together with done.
    always_comb begin
        upd_wipe  = (op_q == OP_WIPE);
        upd_level = (op_q == OP_CONN);
        upd_idx   = {row_q, col_q};
    end
endmodule

// File: rtl/xbar_shadow.sv
// Readable copy of the write-only crosspoint array.
// Assumes commit pulses once per completed slot, with idx, level and wipe valid.
module xbar_shadow #(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic                 wipe,
    input  logic                 level,
    input  logic [IDX_W-1:0]     idx,
    output logic [(1<<IDX_W)-1:0] state
);
    // Apply a completed connect, disconnect or wipe to the stored copy.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= '0;
        else if (commit) begin
            if (wipe)     state <= '0;
            else          state[idx] <= level;
        end
    end
endmodule

// File: rtl/xbar_phase_ctrl.sv
// Top of the phased crosspoint array controller.
// Splits time into four-phase slots, runs one command per slot on the external
// write-only switch devices and mirrors the array state in a shadow register.
// Assumes the sequencer presents commands while phase_o shows the last phase.
module xbar_phase_ctrl
    import xbar_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DEV_SEL_W = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          cmd_op,
    input  logic [ROW_W-1:0]                    cmd_row,
    input  logic [COL_W-1:0]                    cmd_col,
    output logic [1:0]                          phase_o,
    output logic [ROW_W-DEV_SEL_W+COL_W-1:0]    dev_addr,
    output logic                                dev_data,
    output logic [(1<<DEV_SEL_W)-1:0]           dev_cs,
    output logic [(1<<DEV_SEL_W)-1:0]           dev_strobe,
    output logic                                dev_reset,
    output logic                                cmd_done,
    output logic [(1<<(ROW_W+COL_W))-1:0]       shadow
);
    localparam int IDX_W = ROW_W + COL_W;

    logic             en_strobe;
    logic             en_last;
    logic             upd_wipe;
    logic             upd_level;
    logic [IDX_W-1:0] upd_idx;

    xbar_phase_gen #(.PH_W(2)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_o),
        .en_strobe (en_strobe),
        .en_last   (en_last)
    );

    xbar_cmd_seq #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DEV_SEL_W (DEV_SEL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_strobe  (en_strobe),
        .en_last    (en_last),
        .op         (cmd_op),
        .row        (cmd_row),
        .col        (cmd_col),
        .dev_addr   (dev_addr),
        .dev_data   (dev_data),
        .dev_cs     (dev_cs),
        .dev_strobe (dev_strobe),
        .dev_reset  (dev_reset),
        .done       (cmd_done),
        .upd_wipe   (upd_wipe),
        .upd_level  (upd_level),
        .upd_idx    (upd_idx)
    );

    xbar_shadow #(.IDX_W(IDX_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (cmd_done),
        .wipe   (upd_wipe),
        .level  (upd_level),
        .idx    (upd_idx),
        .state  (shadow)
    );
endmodule

// File: rtl/xbar_phase_ctrl_chk.sv
// Property checker for the crosspoint array controller, attached by bind.
// Assumes the same parameters as the bound instance.
module xbar_phase_ctrl_chk #(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DEV_SEL_W = 1
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [1:0]                          phase_o,
    input logic [ROW_W-DEV_SEL_W+COL_W-1:0]    dev_addr,
    input logic                                dev_data,
    input logic [(1<<DEV_SEL_W)-1:0]           dev_cs,
    input logic [(1<<DEV_SEL_W)-1:0]           dev_strobe,
    input logic                                dev_reset,
    input logic                                cmd_done,
    input logic [(1<<(ROW_W+COL_W))-1:0]       shadow
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> (phase_o == $past(phase_o) + 2'd1)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o != 2'd0) && (|dev_cs)) |-> ($stable(dev_addr) && $stable(dev_data))); // R3

    AST_STROBE_ONE_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_strobe)); // R4

    AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_strobe) |-> (phase_o == 2'd1 || phase_o == 2'd2)); // R4

    AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_strobe) |-> ((dev_strobe & ~dev_cs) == '0)); // R5

    AST_WIPE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (dev_cs == '0 && dev_strobe == '0)); // R6

    AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o == 2'd0) && $past(dev_reset)) |-> (shadow == '0)); // R6

    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (phase_o == 2'd3)); // R7

    AST_SHADOW_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> $stable(shadow)); // R8
endmodule

bind xbar_phase_ctrl xbar_phase_ctrl_chk #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .DEV_SEL_W (DEV_SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_o    (phase_o),
    .dev_addr   (dev_addr),
    .dev_data   (dev_data),
    .dev_cs     (dev_cs),
    .dev_strobe (dev_strobe),
    .dev_reset  (dev_reset),
    .cmd_done   (cmd_done),
    .shadow     (shadow)
);

// File: tb/test_xbar_phase_ctrl.sv
// Directed bench for the crosspoint array controller.
module test_xbar_phase_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cmd_op = 2'b00;
    logic [3:0]   cmd_row = '0;
    logic [3:0]   cmd_col = '0;
    logic [1:0]   phase_o;
    logic [6:0]   dev_addr;
    logic         dev_data;
    logic [1:0]   dev_cs;
    logic [1:0]   dev_strobe;
    logic         dev_reset;
    logic         cmd_done;
    logic [255:0] shadow;

    logic [255:0] exp_sh = '0;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    xbar_phase_ctrl i_xbar_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .phase_o(phase_o), .dev_addr(dev_addr),
        .dev_data(dev_data), .dev_cs(dev_cs), .dev_strobe(dev_strobe),
        .dev_reset(dev_reset), .cmd_done(cmd_done), .shadow(shadow)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R9: reset state and the first phase.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9", "phase in reset", 256'(phase_o), 256'(0));
        chk("R9", "pins in reset", 256'({dev_cs, dev_strobe, dev_reset, dev_data, dev_addr}), 256'(0));
        chk("R9", "done in reset", 256'(cmd_done), 256'(0));
        chk("R9", "shadow in reset", shadow, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "shadow after reset", shadow, '0);
        chk("R9", "pins after reset", 256'({dev_cs, dev_strobe, dev_reset}), 256'(0));
    endtask

    // R1: free-running phase sequence.
    task automatic t_phase_walk();
        logic [1:0] prev;
        prev = phase_o;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R1", "phase step", 256'(phase_o), 256'(2'(prev + 2'd1)));
            prev = phase_o;
        end
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10: run one command slot and check every phase.
    task automatic do_cmd(input logic [1:0] op, input logic [3:0] row, input logic [3:0] col);
        logic       wr;
        logic [1:0] cs_e;
        while (phase_o != 2'd3) @(negedge clk);
        cmd_op = op; cmd_row = row; cmd_col = col;
        @(negedge clk);
        cmd_op = 2'b00; cmd_row = '0; cmd_col = '0;
        wr   = (op == 2'b01) || (op == 2'b10);
        cs_e = wr ? (row[3] ? 2'b10 : 2'b01) : 2'b00;
        chk("R8", "shadow at slot start", shadow, exp_sh);
        for (int p = 0; p < 4; p++) begin
            if (p != 0) @(negedge clk);
            chk("R1", "slot phase", 256'(phase_o), 256'(p));
            chk("R5", "select", 256'(dev_cs), 256'(cs_e));
            chk("R4", "strobe", 256'(dev_strobe), 256'((p == 1 || p == 2) ? cs_e : 2'b00));
            chk("R6", "reset line", 256'(dev_reset), 256'(op == 2'b11));
            chk("R7", "done", 256'(cmd_done), 256'((p == 3) && (op != 2'b00)));
            if (wr) begin
                chk("R3", "address", 256'(dev_addr), 256'({row[2:0], col}));
                chk("R3", "data", 256'(dev_data), 256'(op == 2'b01));
            end
            if (op == 2'b00)
                chk("R2", "idle leaves shadow", shadow, exp_sh);
        end
        if (op == 2'b01) exp_sh[{row, col}] = 1'b1;
        if (op == 2'b10) exp_sh[{row, col}] = 1'b0;
        if (op == 2'b11) exp_sh = '0;
    endtask

    // R2: a command held over phases 0..2 only is ignored.
    task automatic t_stray(input logic [1:0] op, input logic [3:0] row, input logic [3:0] col);
        while (phase_o != 2'd0) @(negedge clk);
        cmd_op = op; cmd_row = row; cmd_col = col;
        for (int p = 1; p < 4; p++) begin
            @(negedge clk);
            if (p == 3) begin cmd_op = 2'b00; cmd_row = '0; cmd_col = '0; end
        end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            chk("R2", "stray select", 256'({dev_cs, dev_strobe, dev_reset}), 256'(0));
            chk("R2", "stray done", 256'(cmd_done), 256'(0));
        end
        chk("R2", "stray shadow", shadow, exp_sh);
    endtask

    // R8: final shadow check one slot later.
    task automatic t_flush();
        do_cmd(2'b00, 4'd0, 4'd0);
        @(negedge clk);
        chk("R8", "final shadow", shadow, exp_sh);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_phase_walk();
        do_cmd(2'b01, 4'd3, 4'd5);      // R3 device 0
        do_cmd(2'b01, 4'd12, 4'd0);     // R10 back to back, device 1
        do_cmd(2'b01, 4'd15, 4'd15);    // top corner
        do_cmd(2'b01, 4'd0, 4'd0);      // bottom corner
        do_cmd(2'b01, 4'd8, 4'd9);      // device boundary
        do_cmd(2'b10, 4'd12, 4'd0);     // R8 clear one bit
        do_cmd(2'b00, 4'd7, 4'd7);      // R2 idle
        t_stray(2'b01, 4'd6, 4'd6);     // R2 off-phase connect
        t_stray(2'b11, 4'd0, 4'd0);     // R2 off-phase wipe
        do_cmd(2'b10, 4'd1, 4'd1);      // disconnect of open point
        do_cmd(2'b11, 4'd0, 4'd0);      // R6 wipe
        do_cmd(2'b01, 4'd9, 4'd2);      // R10 after wipe
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule